// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor port and a main-memory port and keeps recently used memory words in local storage. A byte address is split into a tag (upper bits), a set index (middle bits) and a byte offset (lowest bits). Each set holds two lines, and each line holds one four-byte block. On every request the tags of both lines in the indexed set are compared at the same time. A match is answered from local storage without any memory traffic.

On a miss the controller chooses a victim line. An invalid line is taken first. If both lines are valid, the least recently used one is taken. If the victim holds modified data, it is first written back to memory. The missing block is then fetched, and the request is compared again, so it completes as a hit.

Writes merge the selected bytes into the cached line and set the line's modified flag; memory is not written at that time. The set count is a parameter. With `SET_W = 13` the 24-bit address splits into a 9-bit tag, a 13-bit index and a 2-bit offset. The default is smaller so that elaboration stays light.

Top module: `assoc2_wb_cache`

## Requirements
- R1: The address is decoded as tag = addr[23:SET_W+2], set index = addr[SET_W+1:2], offset = addr[1:0]. Addresses that differ only in the set index never evict each other. Addresses with the same index and different tags compete for the two lines of one set.
- R2: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R3: A hit raises `cpu_ready` exactly one cycle after the cycle in which the request was accepted, with no memory request.
- R4: A read miss issues one memory read of the line-aligned address (offset bits zero). `cpu_ready` rises only after that read is acknowledged, and the returned data comes from the fetched block.
- R5: A write merges the bytes selected by `cpu_be` into the cached line and marks it modified, without any memory write at that time.
- R6: When the victim line is valid and modified, it is written to memory at its own line address, with its current data, before the refill read is issued.
- R7: A clean or invalid victim is replaced without any memory write.
- R8: An invalid line of the set is filled before any valid one. Otherwise the victim is the line of the set not touched by the most recent hit or fill.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the raising of `mem_req` until `mem_ack`. Only one memory transfer is outstanding at a time.
- R10: `cpu_ready` is high for exactly one cycle per completed access.
- R11: The offset rotates data between the processor lanes and the line. `cpu_rdata` lane 0 carries the byte at the addressed offset, and the write lanes and `cpu_be` bits are rotated the same way before the merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8*LINE_BYTES | Write data, lanes relative to the offset |
| cpu_be | input | LINE_BYTES | Byte enables, relative to the offset |
| cpu_rdata | output | 8*LINE_BYTES | Read data, rotated so lane 0 is the addressed byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 8*LINE_BYTES | Write-back data |
| mem_rdata | input | 8*LINE_BYTES | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle shape of `cpu_ready`;
- that memory requests stay stable until acknowledged;
- that an acknowledged write-back is always followed by a refill read;
- that an acknowledged refill leads straight to a completing hit;
- the state of the clean and modified flags and of the recency bit after fills, write hits and touches.

Only the bench scenarios can show the following, because they depend on access history:
- the choice of victim among the two lines;
- the data carried by an eviction;
- the absence of memory traffic on hits and on clean replacement;
- the byte merging and offset rotation, checked against a reference memory.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_COMPARE   = 2'd1,
      ST_WRITEBACK = 2'd2,
      ST_REFILL    = 2'd3
   } cstate_t;

   localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
   parameter int unsigned SET_W  = 8,
   parameter int unsigned TAG_W  = 14,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] upd_data
);
   localparam int unsigned SETS = 1 << SET_W;

   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[rd_idx] <= 1'b1;
         dirty_q[rd_idx] <= 1'b0;
      end else if (upd_en) begin
         dirty_q[rd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[rd_idx]  <= fill_tag;
         data_q[rd_idx] <= fill_data;
      end else if (upd_en) begin
         data_q[rd_idx] <= upd_data;
      end
   end

   always_comb begin
      rd_valid = valid_q[rd_idx];
      rd_dirty = dirty_q[rd_idx];
      rd_tag   = tag_q[rd_idx];
      rd_data  = data_q[rd_idx];
   end

   AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_q[$past(rd_idx)] && !dirty_q[$past(rd_idx)])); // R7
   AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !fill_en) |=> dirty_q[$past(rd_idx)]); // R5

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
   parameter int unsigned SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_idx,
   output logic             lru_way,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_idx,
   input  logic             touch_way
);
   localparam int unsigned SETS = 1 << SET_W;

   logic [SETS-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) older_q <= '0;
      else if (touch_en) older_q[touch_idx] <= ~touch_way;
   end

   assign lru_way = older_q[rd_idx];

   AST_TOUCH_FLIPS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (older_q[$past(touch_idx)] != $past(touch_way))); // R8

endmodule

// File: rtl/assoc2_wb_cache.sv
module assoc2_wb_cache
   import cache2w_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned SET_W      = 8,
   parameter int unsigned LINE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [8*LINE_BYTES-1:0] cpu_wdata,
   input  logic [LINE_BYTES-1:0]   cpu_be,
   output logic [8*LINE_BYTES-1:0] cpu_rdata,
   output logic                    cpu_ready,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [8*LINE_BYTES-1:0] mem_wdata,
   input  logic [8*LINE_BYTES-1:0] mem_rdata,
   input  logic                    mem_ack
);
   localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
   localparam int unsigned DATA_W = 8 * LINE_BYTES;
   localparam int unsigned TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int unsigned SH_W   = OFF_W + 3;

   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_chk_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (SET_W < 1 || ADDR_W <= SET_W + OFF_W) begin : g_chk_split
      $error("address too narrow for the set index and offset");
   end

   cstate_t state_q;
   logic [TAG_W-1:0]  q_tag;
   logic [SET_W-1:0]  q_set;
   logic [OFF_W-1:0]  q_off;
   logic              q_we;
   logic [DATA_W-1:0] q_wdata;
   logic [LINE_BYTES-1:0] q_be;
   logic              vict_q;

   logic [NUM_WAYS-1:0] w_valid, w_dirty, w_hit, w_fill, w_upd;
   logic [TAG_W-1:0]    w_tag  [NUM_WAYS];
   logic [DATA_W-1:0]   w_data [NUM_WAYS];

   logic              hit, hit_way, victim, lru_way;
   logic [DATA_W-1:0] hit_data, merged, vict_data;
   logic [SH_W-1:0]   shamt;
   logic [2*DATA_W-1:0] rd_dbl, wd_dbl;
   logic [2*LINE_BYTES-1:0] be_dbl;
   logic [DATA_W-1:0] wd_abs;
   logic [LINE_BYTES-1:0] be_abs;
   logic              touch_en, touch_way;

   // request capture and control sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         q_tag   <= '0;
         q_set   <= '0;
         q_off   <= '0;
         q_we    <= 1'b0;
         q_wdata <= '0;
         q_be    <= '0;
         vict_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cpu_req) begin
               q_tag   <= cpu_addr[ADDR_W-1:SET_W+OFF_W];
               q_set   <= cpu_addr[SET_W+OFF_W-1:OFF_W];
               q_off   <= cpu_addr[OFF_W-1:0];
               q_we    <= cpu_we;
               q_wdata <= cpu_wdata;
               q_be    <= cpu_be;
               state_q <= ST_COMPARE;
            end
            ST_COMPARE: begin
               if (hit) begin
                  state_q <= ST_IDLE;
               end else begin
                  vict_q  <= victim;
                  state_q <= (w_valid[victim] && w_dirty[victim]) ? ST_WRITEBACK : ST_REFILL;
               end
            end
            ST_WRITEBACK: if (mem_ack) state_q <= ST_REFILL;
            ST_REFILL:    if (mem_ack) state_q <= ST_COMPARE;
            default:      state_q <= ST_IDLE;
         endcase
      end
   end

   // way storage and parallel tag comparison
   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      cache2w_way #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_idx    (q_set),
         .rd_valid  (w_valid[w]),
         .rd_dirty  (w_dirty[w]),
         .rd_tag    (w_tag[w]),
         .rd_data   (w_data[w]),
         .fill_en   (w_fill[w]),
         .fill_tag  (q_tag),
         .fill_data (mem_rdata),
         .upd_en    (w_upd[w]),
         .upd_data  (merged)
      );
      assign w_hit[w]  = w_valid[w] && (w_tag[w] == q_tag);
      assign w_fill[w] = (state_q == ST_REFILL) && mem_ack && (vict_q == w[0]);
      assign w_upd[w]  = (state_q == ST_COMPARE) && w_hit[w] && q_we;
   end

   assign hit      = (state_q == ST_COMPARE) && (|w_hit);
   assign hit_way  = w_hit[1];
   assign hit_data = w_data[hit_way];

   // victim choice: empty line first, then the older line
   always_comb begin
      if (!w_valid[0])      victim = 1'b0;
      else if (!w_valid[1]) victim = 1'b1;
      else                  victim = lru_way;
   end
   assign vict_data = w_data[vict_q];

   // offset rotation between processor lanes and the line
   assign shamt  = {q_off, 3'b000};
   assign rd_dbl = {hit_data, hit_data} >> shamt;
   assign wd_dbl = {q_wdata, q_wdata} << shamt;
   assign be_dbl = {q_be, q_be} << q_off;
   assign wd_abs = wd_dbl[2*DATA_W-1:DATA_W];
   assign be_abs = be_dbl[2*LINE_BYTES-1:LINE_BYTES];

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
      assign merged[8*b +: 8] = be_abs[b] ? wd_abs[8*b +: 8] : hit_data[8*b +: 8];
   end

   // recency tracking per set
   assign touch_en  = hit || ((state_q == ST_REFILL) && mem_ack);
   assign touch_way = hit ? hit_way : vict_q;

   cache2w_lru #(.SET_W(SET_W)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (q_set),
      .lru_way   (lru_way),
      .touch_en  (touch_en),
      .touch_idx (q_set),
      .touch_way (touch_way)
   );

   // ports
   assign cpu_ready = hit;
   assign cpu_rdata = rd_dbl[DATA_W-1:0];
   assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
   assign mem_we    = (state_q == ST_WRITEBACK);
   assign mem_addr  = mem_we ? {w_tag[vict_q], q_set, {OFF_W{1'b0}}}
                             : {q_tag, q_set, {OFF_W{1'b0}}};
   assign mem_wdata = vict_data;

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R10
   AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R9
   AST_WRITEBACK_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R6
   AST_REFILL_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> cpu_ready); // R4
   AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> (!mem_req && !$past(mem_req && !mem_ack))); // R3

endmodule

// File: tb/tb_assoc2_wb_cache.sv
`timescale 1ns/100ps
module tb_assoc2_wb_cache;
   localparam int AW = 24;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic [31:0] cpu_rdata;
   logic cpu_ready, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic mem_ack = 1'b0;

   always #2.5 clk = ~clk;

   assoc2_wb_cache #(.ADDR_W(AW), .SET_W(SW), .LINE_BYTES(4)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] mem_arr [int];
   logic [31:0] ref_arr [int];
   int mem_lat = 1;
   int lat_cnt = 0;
   int n_wr = 0;
   int n_rd = 0;
   logic [AW-1:0] wb_addr = '0;
   logic [31:0] wb_data = '0;

   function automatic logic [31:0] init_word(int line);
      return (32'(line) * 32'h9E37_79B1) ^ 32'hC3A5_1F07;
   endfunction
   function automatic logic [31:0] mem_get(int line);
      return mem_arr.exists(line) ? mem_arr[line] : init_word(line);
   endfunction
   function automatic logic [31:0] ref_get(int line);
      return ref_arr.exists(line) ? ref_arr[line] : init_word(line);
   endfunction
   function automatic logic [31:0] rotr(logic [31:0] w, logic [1:0] off);
      logic [63:0] d = {w, w} >> (8 * off);
      return d[31:0];
   endfunction
   function automatic logic [31:0] rotl(logic [31:0] w, logic [1:0] off);
      logic [63:0] d = {w, w} << (8 * off);
      return d[63:32];
   endfunction
   function automatic logic [3:0] rotl_be(logic [3:0] b, logic [1:0] off);
      logic [7:0] d = {b, b} << off;
      return d[7:4];
   endfunction
   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
      logic [31:0] r = old;
      for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = wd[8*i +: 8];
      return r;
   endfunction

   // memory model: acknowledges after mem_lat idle cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt >= mem_lat) begin
            lat_cnt <= 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem_arr[int'(mem_addr >> 2)] = mem_wdata;
               n_wr++;
               wb_addr <= mem_addr;
               wb_data <= mem_wdata;
            end else begin
               mem_rdata <= mem_get(int'(mem_addr >> 2));
               n_rd++;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output int lat);
      int line;
      logic [1:0] off;
      logic [31:0] got, exp;
      line = int'(a >> 2);
      off  = a[1:0];
      @(negedge clk);
      check(cpu_ready == 1'b0, "R10 ready gap", 32'(cpu_ready), 32'd0);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_ready);
      got = cpu_rdata;
      cpu_req = 1'b0;
      if (!we) begin
         exp = rotr(ref_get(line), off);
         check(got == exp, "R4 R11 read data", got, exp);
      end else begin
         ref_arr[line] = merge(ref_get(line), rotl(wd, off), rotl_be(be, off));
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   localparam logic [AW-1:0] A = 24'h000100;   // set 64
   localparam logic [AW-1:0] B = A + 24'h400;  // same set, other tag
   localparam logic [AW-1:0] C = A + 24'h800;
   localparam logic [AW-1:0] D = A + 24'hC00;
   localparam logic [AW-1:0] E = A + 24'h004;  // next set

   initial begin
      int lat, rd0, wr0;
      logic [31:0] a_word;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2 reset state
      check(cpu_ready == 1'b0, "R2 ready after reset", 32'(cpu_ready), 32'd0);
      check(mem_req == 1'b0, "R2 mem_req after reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      // R2 R4 first read misses and refills the aligned line
      rd0 = n_rd;
      do_op(1'b0, A, '0, '0, lat);
      check(n_rd == rd0 + 1, "R2 R4 refill count", 32'(n_rd), 32'(rd0 + 1));
      check(lat > 1, "R4 miss latency", 32'(lat), 32'd2);

      // R3 hit in one cycle, no memory traffic
      rd0 = n_rd;
      do_op(1'b0, A + 24'd1, '0, '0, lat);
      check(lat == 1, "R3 hit latency", 32'(lat), 32'd1);
      check(n_rd == rd0, "R3 no refill on hit", 32'(n_rd), 32'(rd0));

      // R5 R11 write hit with offset, memory untouched
      wr0 = n_wr;
      do_op(1'b1, A + 24'd2, 32'h0000_11AB, 4'b0011, lat);
      check(lat == 1, "R5 write hit latency", 32'(lat), 32'd1);
      check(n_wr == wr0, "R5 no memory write", 32'(n_wr), 32'(wr0));
      do_op(1'b0, A, '0, '0, lat);
      a_word = ref_get(int'(A >> 2));
      check(a_word[23:16] == 8'hAB, "R11 byte lane placement", 32'(a_word[23:16]), 32'hAB);

      // R1 neighbouring set does not conflict
      do_op(1'b0, E, '0, '0, lat);
      rd0 = n_rd;
      do_op(1'b0, A, '0, '0, lat);
      check(lat == 1 && n_rd == rd0, "R1 other set keeps line", 32'(lat), 32'd1);

      // R8 invalid way filled before any eviction
      rd0 = n_rd;
      do_op(1'b0, B, '0, '0, lat);
      do_op(1'b0, A, '0, '0, lat);
      check(lat == 1 && n_rd == rd0 + 1, "R8 empty way used first", 32'(lat), 32'd1);

      // R7 R8 clean older line B replaced, no write-back
      wr0 = n_wr;
      do_op(1'b0, C, '0, '0, lat);
      check(n_wr == wr0, "R7 clean victim no write", 32'(n_wr), 32'(wr0));
      rd0 = n_rd;
      do_op(1'b0, A, '0, '0, lat);
      check(lat == 1 && n_rd == rd0, "R8 recent line survives", 32'(lat), 32'd1);
      do_op(1'b0, C, '0, '0, lat);   // A now older

      // R6 dirty A evicted with its address and data
      wr0 = n_wr;
      do_op(1'b0, D, '0, '0, lat);
      check(n_wr == wr0 + 1, "R6 one write-back", 32'(n_wr), 32'(wr0 + 1));
      check(wb_addr == A, "R6 write-back address", 32'(wb_addr), 32'(A));
      check(wb_data == a_word, "R6 write-back data", wb_data, a_word);
      rd0 = n_rd;
      do_op(1'b0, A + 24'd3, '0, '0, lat);
      check(n_rd == rd0 + 1, "R6 R1 A re-fetched", 32'(n_rd), 32'(rd0 + 1));

      // random mix over a small conflicting pool
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] ra;
         mem_lat = int'($urandom_range(0, 3));
         ra = AW'(($urandom_range(0, 3) << 10) | ($urandom_range(3, 4) << 2) | $urandom_range(0, 3));
         do_op(($urandom_range(0, 9) < 4), ra, $urandom, 4'($urandom_range(0, 15)), lat);
      end
      finish_run();
   end
endmodule